// File: doc/BRIEF.md
# Load-Store Dependence Predictor

This block decides whether a load may run ahead of older stores whose addresses are still unknown. It keeps a direct-mapped table of confidence counters indexed by a fold of the load's instruction address. A load that has faced unknown stores and was never hit by a conflicting store earns confidence. A load that was caught reading too early loses all confidence at once. Only a load whose counter is at its ceiling is allowed past unresolved stores.

The pipeline calls the block at four points. At dispatch it asks for a go/block decision and opens a tracking entry for the load. When a store address resolves, the block snoops all younger loads for a conflict. At commit it trains the table from what that load's entry recorded. A guard watches the rate of conflicts over windows of committed loads and switches speculation off for a while when conflicts become too frequent.

Top module: `ldst_dep_pred`

## Requirements
- R1: The table index is instruction-address bits [7:2] XORed with bits [13:8], where `disp_pc_bits[11:0]` carries address bits [13:2]. Two loads whose folded indices are equal share one counter.
- R2: After reset all counters are zero, the guard is idle and `res_valid` is low. A load that faces an unknown older store is therefore blocked.
- R3: A lookup on `disp_valid` yields `res_valid`, `res_slot` and `res_go` exactly one cycle later. `res_go` is 1 when `disp_older_unknown` is 0. Otherwise it is 1 only if the counter equals 15 and the guard is not blocking.
- R4: A dispatch records whether an older store address was unknown. A load dispatched with `disp_older_unknown` = 0 never changes the table at commit.
- R5: A store resolve marks a load entry as conflicting only under all of these conditions:
  - its bit in `st_younger_mask` (bit i = slot i) is 1;
  - the entry is valid;
  - the load was given go;
  - its address equals the store address at 8-byte granularity (byte address bits [31:3]).
- R6: At commit of a load that faced an unknown store, a conflicting load clears its counter to 0. Otherwise the counter increments and saturates at 15.
- R7: A lookup in the same cycle as a commit update to the same index sees the counter value from before the update.
- R8: When more than 8 conflicting loads commit within a window of 256 committed loads, every lookup that faces an unknown store is blocked during the next 256 committed loads. After that, normal prediction resumes.
- R9: A window with exactly 8 conflicting loads does not start blocking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_valid | input | 1 | Load dispatch lookup request |
| disp_slot | input | 4 | Load-buffer slot of the dispatching load |
| disp_pc_bits | input | 12 | Instruction address bits [13:2] of the load |
| disp_dw_addr | input | 29 | Load byte address bits [31:3] |
| disp_older_unknown | input | 1 | An older store with unknown address exists |
| res_valid | output | 1 | Decision valid, one cycle after lookup |
| res_slot | output | 4 | Slot the decision belongs to |
| res_go | output | 1 | 1 = issue now, 0 = stay blocked |
| st_valid | input | 1 | A store address has resolved |
| st_dw_addr | input | 29 | Store byte address bits [31:3] |
| st_younger_mask | input | 16 | Bit i set when slot i is younger than the store |
| cm_valid | input | 1 | Load commit |
| cm_slot | input | 4 | Slot of the committing load |

## Verification
A lookup's decision appears on the result port one clock after the dispatch edge. A commit changes the table and the guard at its own edge, so a lookup driven in the next cycle is the first to see it. A store resolve changes a load's entry at its edge, and that change only shows up when the load commits. The bench drives each event at a falling edge and pushes the decision it expects into a queue. A monitor pops and compares entries only at falling edges where `res_valid` is high, so each check lands exactly one clock after its lookup. Table and guard effects are checked through decisions on later lookups.

// File: rtl/ldp_pkg.sv
// Shared types for the load-store dependence predictor.
// Assumes nothing beyond IEEE 1800-2017 packed structs.
package ldp_pkg;

    // Outcome bits kept per in-flight load.
    typedef struct packed {
        logic upd;   // an older store address was unknown at dispatch
        logic done;  // the load was allowed to issue
        logic rst;   // a resolved store hit this load after it issued
    } ldp_track_t;

endpackage

// File: rtl/ldp_hist_table.sv
// Confidence table: one saturating counter per index.
// Read is combinational and sees the value before any same-cycle write.
// Assumes at most one training write per cycle.
module ldp_hist_table #(
    parameter int IDX_W = 6,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CNT_W-1:0] rd_cnt,
    input  logic             tr_en,
    input  logic [IDX_W-1:0] tr_idx,
    input  logic             tr_clear
);
    localparam int               ENTRIES = 1 << IDX_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q [ENTRIES];

    // Lookup read of the stored counter.
    assign rd_cnt = cnt_q[rd_idx];

    // Counter storage: clear on failure, saturating increment on success.
    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (!rst_n) begin
                cnt_q[i] <= '0;
            end else if (tr_en && tr_idx == IDX_W'(i)) begin
                if (tr_clear)
                    cnt_q[i] <= '0;
                else if (cnt_q[i] != CNT_MAX)
                    cnt_q[i] <= cnt_q[i] + CNT_W'(1);
            end
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_chk
        p_clear_on_fail_r6: assert property (@(posedge clk) disable iff (!rst_n)
            tr_en && tr_idx == IDX_W'(g) && tr_clear |=> cnt_q[g] == '0);
        p_sat_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
            tr_en && tr_idx == IDX_W'(g) && !tr_clear && cnt_q[g] != CNT_MAX
            |=> cnt_q[g] == $past(cnt_q[g]) + CNT_W'(1));
        p_hold_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
            tr_en && tr_idx == IDX_W'(g) && !tr_clear && cnt_q[g] == CNT_MAX
            |=> cnt_q[g] == CNT_MAX);
    end
endmodule

// File: rtl/ldp_load_buffer.sv
// Per-load tracking entries: table index, aligned address and outcome bits.
// Dispatch opens or refreshes an entry, a store resolve snoops the younger
// entries, and a commit reads out one entry and frees it.
// Assumes dispatch and commit never target the same slot in one cycle.
module ldp_load_buffer
    import ldp_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int IDX_W = 6,
    parameter int DW_W  = 29,
    localparam int SLOT_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              al_en,
    input  logic [SLOT_W-1:0] al_slot,
    input  logic [IDX_W-1:0]  al_idx,
    input  logic [DW_W-1:0]   al_addr,
    input  logic              al_upd,
    input  logic              al_go,
    input  logic              sn_en,
    input  logic [DW_W-1:0]   sn_addr,
    input  logic [DEPTH-1:0]  sn_mask,
    input  logic              cm_en,
    input  logic [SLOT_W-1:0] cm_slot,
    output logic [IDX_W-1:0]  cm_idx,
    output ldp_track_t        cm_trk
);
    logic [DEPTH-1:0] vld_q;
    logic [IDX_W-1:0] idx_q  [DEPTH];
    logic [DW_W-1:0]  addr_q [DEPTH];
    ldp_track_t       trk_q  [DEPTH];

    // Commit read-out of the selected entry.
    assign cm_idx = idx_q[cm_slot];
    assign cm_trk = trk_q[cm_slot];

    // Entry update: snoop, then dispatch, then commit (later wins).
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) begin
                vld_q[i]  <= 1'b0;
                idx_q[i]  <= '0;
                addr_q[i] <= '0;
                trk_q[i]  <= '0;
            end else begin
                if (sn_en && sn_mask[i] && vld_q[i] && trk_q[i].done
                    && addr_q[i] == sn_addr)
                    trk_q[i].rst <= 1'b1;
                if (al_en && al_slot == SLOT_W'(i)) begin
                    vld_q[i]  <= 1'b1;
                    idx_q[i]  <= al_idx;
                    addr_q[i] <= al_addr;
                    if (!vld_q[i]) begin
                        trk_q[i] <= '{upd: al_upd, done: al_go, rst: 1'b0};
                    end else begin
                        trk_q[i].upd  <= trk_q[i].upd | al_upd;
                        trk_q[i].done <= trk_q[i].done | al_go;
                    end
                end
                if (cm_en && cm_slot == SLOT_W'(i))
                    vld_q[i] <= 1'b0;
            end
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_chk
        p_conflict_needs_issue_r5: assert property (@(posedge clk) disable iff (!rst_n)
            trk_q[g].rst |-> trk_q[g].done);
        p_commit_frees_r4: assert property (@(posedge clk) disable iff (!rst_n)
            cm_en && cm_slot == SLOT_W'(g) && !(al_en && al_slot == SLOT_W'(g))
            |=> !vld_q[g]);
    end
endmodule

// File: rtl/ldp_spec_guard.sv
// Misprediction guard: counts conflicting commits per window of committed
// loads and forces blocking for a hold period when the count is too high.
// Windows are not counted while blocking; a fresh window starts afterwards.
module ldp_spec_guard #(
    parameter int WIN   = 256,
    parameter int LIMIT = 8,
    parameter int HOLD  = 256,
    localparam int WC_W = $clog2(WIN),
    localparam int RC_W = $clog2(WIN + 1),
    localparam int HC_W = $clog2(HOLD)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cm_en,
    input  logic cm_failed,
    output logic block
);
    logic            blk_q;
    logic [WC_W-1:0] win_q;
    logic [RC_W-1:0] rc_q;
    logic [HC_W-1:0] hc_q;
    logic [RC_W-1:0] rc_nxt;
    logic            win_last;

    // Running failure count including the current commit.
    always_comb begin
        rc_nxt   = rc_q + RC_W'(cm_failed);
        win_last = (win_q == WC_W'(WIN - 1));
    end

    // Window / hold sequencing on each committed load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q <= 1'b0;
            win_q <= '0;
            rc_q  <= '0;
            hc_q  <= '0;
        end else if (cm_en) begin
            if (blk_q) begin
                if (hc_q == HC_W'(HOLD - 1)) begin
                    blk_q <= 1'b0;
                    hc_q  <= '0;
                end else begin
                    hc_q <= hc_q + HC_W'(1);
                end
            end else if (win_last) begin
                blk_q <= (rc_nxt > RC_W'(LIMIT));
                win_q <= '0;
                rc_q  <= '0;
            end else begin
                win_q <= win_q + WC_W'(1);
                rc_q  <= rc_nxt;
            end
        end
    end

    assign block = blk_q;

    p_block_starts_on_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(blk_q) |-> $past(cm_en));
    p_block_ends_on_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(blk_q) |-> $past(cm_en));
    p_quiet_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cm_en |=> $stable(blk_q));
endmodule

// File: rtl/ldst_dep_pred.sv
// Load-store dependence predictor top. Folds the instruction address into
// a table index, gives a registered go/block decision, tracks each load in
// the load buffer and trains the table at commit.
// Assumes the caller passes address bits [13:2] and 8-byte-aligned addresses.
module ldst_dep_pred
    import ldp_pkg::*;
#(
    parameter int LB_DEPTH   = 16,
    parameter int IDX_W      = 6,
    parameter int CNT_W      = 4,
    parameter int ADDR_W     = 32,
    parameter int ALIGN_W    = 3,
    parameter int WIN_LOADS  = 256,
    parameter int FAIL_LIMIT = 8,
    parameter int HOLD_LOADS = 256,
    localparam int SLOT_W = $clog2(LB_DEPTH),
    localparam int DW_W   = ADDR_W - ALIGN_W,
    localparam int PC_W   = 2 * IDX_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                disp_valid,
    input  logic [SLOT_W-1:0]   disp_slot,
    input  logic [PC_W-1:0]     disp_pc_bits,
    input  logic [DW_W-1:0]     disp_dw_addr,
    input  logic                disp_older_unknown,
    output logic                res_valid,
    output logic [SLOT_W-1:0]   res_slot,
    output logic                res_go,
    input  logic                st_valid,
    input  logic [DW_W-1:0]     st_dw_addr,
    input  logic [LB_DEPTH-1:0] st_younger_mask,
    input  logic                cm_valid,
    input  logic [SLOT_W-1:0]   cm_slot
);
    logic [IDX_W-1:0] look_idx;
    logic [CNT_W-1:0] look_cnt;
    logic             look_go;
    logic             wd_block;
    logic [IDX_W-1:0] cm_idx;
    ldp_track_t       cm_trk;

    // Index fold and go/block decision for the dispatching load.
    always_comb begin
        look_idx = disp_pc_bits[IDX_W-1:0] ^ disp_pc_bits[PC_W-1:IDX_W];
        look_go  = !disp_older_unknown || ((&look_cnt) && !wd_block);
    end

    ldp_hist_table #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (look_idx),
        .rd_cnt   (look_cnt),
        .tr_en    (cm_valid && cm_trk.upd),
        .tr_idx   (cm_idx),
        .tr_clear (cm_trk.rst)
    );

    ldp_load_buffer #(.DEPTH(LB_DEPTH), .IDX_W(IDX_W), .DW_W(DW_W)) u_lbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .al_en   (disp_valid),
        .al_slot (disp_slot),
        .al_idx  (look_idx),
        .al_addr (disp_dw_addr),
        .al_upd  (disp_older_unknown),
        .al_go   (look_go),
        .sn_en   (st_valid),
        .sn_addr (st_dw_addr),
        .sn_mask (st_younger_mask),
        .cm_en   (cm_valid),
        .cm_slot (cm_slot),
        .cm_idx  (cm_idx),
        .cm_trk  (cm_trk)
    );

    ldp_spec_guard #(.WIN(WIN_LOADS), .LIMIT(FAIL_LIMIT), .HOLD(HOLD_LOADS)) u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .cm_en     (cm_valid),
        .cm_failed (cm_trk.rst),
        .block     (wd_block)
    );

    // Registered decision, one cycle after the lookup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_slot  <= '0;
            res_go    <= 1'b0;
        end else begin
            res_valid <= disp_valid;
            res_slot  <= disp_slot;
            res_go    <= disp_valid && look_go;
        end
    end

    p_result_follows_lookup_r3: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(disp_valid));
    p_safe_load_goes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid && !disp_older_unknown |=> res_valid && res_go);
    p_guard_forces_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid && disp_older_unknown && wd_block |=> res_valid && !res_go);
endmodule

// File: tb/ldst_dep_pred_tb_top.sv
// Scoreboard bench: driver tasks queue the expected decision of every lookup,
// a monitor compares decisions as they appear one cycle later.
module ldst_dep_pred_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        disp_valid = 1'b0;
    logic [3:0]  disp_slot = '0;
    logic [11:0] disp_pc_bits = '0;
    logic [28:0] disp_dw_addr = '0;
    logic        disp_older_unknown = 1'b0;
    logic        res_valid;
    logic [3:0]  res_slot;
    logic        res_go;
    logic        st_valid = 1'b0;
    logic [28:0] st_dw_addr = '0;
    logic [15:0] st_younger_mask = '0;
    logic        cm_valid = 1'b0;
    logic [3:0]  cm_slot = '0;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    typedef struct {
        int    slot;
        bit    go;
        string req;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    ldst_dep_pred dut_i (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_slot(disp_slot), .disp_pc_bits(disp_pc_bits),
        .disp_dw_addr(disp_dw_addr), .disp_older_unknown(disp_older_unknown),
        .res_valid(res_valid), .res_slot(res_slot), .res_go(res_go),
        .st_valid(st_valid), .st_dw_addr(st_dw_addr), .st_younger_mask(st_younger_mask),
        .cm_valid(cm_valid), .cm_slot(cm_slot)
    );

    localparam int IP_A   = 32'h40;    // index 16
    localparam int IP_AL  = 32'h1000;  // aliases IP_A
    localparam int IP_N   = 32'h44;    // index 17
    localparam int IP_B   = 32'h88;
    localparam int IP_C   = 32'hC8;
    localparam int IP_D   = 32'h104;
    localparam int IP_E   = 32'h400;

    // Monitor: pop and compare at each falling edge carrying a decision.
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            exp_t e;
            checks++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL unexpected decision: slot %0d go %0b, expected none", res_slot, res_go);
            end else begin
                e = sb.pop_front();
                if (res_go !== e.go || res_slot !== 4'(e.slot)) begin
                    fails++;
                    $display("FAIL %s: slot %0d go %0b, expected slot %0d go %0b",
                             e.req, res_slot, res_go, e.slot, e.go);
                end
            end
        end
    end

    task automatic clear_all();
        disp_valid = 1'b0; disp_older_unknown = 1'b0;
        st_valid = 1'b0; st_younger_mask = '0;
        cm_valid = 1'b0;
    endtask

    task automatic set_disp(input int slot, input int ip, input int addr,
                            input bit unk, input bit exp_go, input string req);
        disp_valid = 1'b1;
        disp_slot = 4'(slot);
        disp_pc_bits = 12'(ip >> 2);
        disp_dw_addr = 29'(addr >> 3);
        disp_older_unknown = unk;
        sb.push_back('{slot, exp_go, req});
    endtask

    // One load: dispatch, optional store resolve, commit.
    task automatic step(input int slot, input int ip, input int addr, input bit unk,
                        input bit exp_go, input string req, input bit st_en = 1'b0,
                        input int st_addr = 0, input int st_mask = 0);
        set_disp(slot, ip, addr, unk, exp_go, req);
        @(negedge clk); clear_all();
        if (st_en) begin
            st_valid = 1'b1; st_dw_addr = 29'(st_addr >> 3); st_younger_mask = 16'(st_mask);
            @(negedge clk); clear_all();
        end
        cm_valid = 1'b1; cm_slot = 4'(slot);
        @(negedge clk); clear_all();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        clear_all();
        do_reset();

        // R2: no decision out of reset
        checks++;
        if (res_valid !== 1'b0) begin
            fails++;
            $display("FAIL R2: res_valid %0b, expected 0", res_valid);
        end

        // R2/R3/R6: train IP_A; blocked until its counter reaches 15
        for (int k = 0; k < 16; k++)
            step(0, IP_A, 32'h100, 1'b1, k == 15, (k == 0) ? "R2" : "R6");

        // R1: alias shares the saturated counter, a neighbour index does not
        step(1, IP_AL, 32'h100, 1'b1, 1'b1, "R1");
        step(1, IP_N, 32'h100, 1'b1, 1'b0, "R1");

        // R3: no unknown store means go even with a cold counter
        step(2, IP_N, 32'h100, 1'b0, 1'b1, "R3");

        // R4: loads without unknown stores do not train
        for (int k = 0; k < 20; k++)
            step(2, IP_D, 32'h200, 1'b0, 1'b1, "R4");
        step(2, IP_D, 32'h200, 1'b1, 1'b0, "R4");

        // R5: conflict on an issued load clears its counter
        for (int k = 0; k < 15; k++)
            step(3, IP_B, 32'h1000, 1'b1, 1'b0, "R6");
        step(3, IP_B, 32'h1000, 1'b1, 1'b1, "R5", 1'b1, 32'h1007, 1 << 3);
        step(3, IP_B, 32'h1000, 1'b1, 1'b0, "R5");
        // R5: blocked (not issued) load is not marked by a matching store
        step(3, IP_B, 32'h1000, 1'b1, 1'b0, "R5", 1'b1, 32'h1000, 1 << 3);
        for (int k = 0; k < 13; k++)
            step(3, IP_B, 32'h1000, 1'b1, 1'b0, "R5");
        step(3, IP_B, 32'h1000, 1'b1, 1'b1, "R5");

        // R5: different 8-byte block, and store not older than load
        for (int k = 0; k < 15; k++)
            step(4, IP_C, 32'h1000, 1'b1, 1'b0, "R6");
        step(4, IP_C, 32'h1000, 1'b1, 1'b1, "R5", 1'b1, 32'h1008, 1 << 4);
        step(4, IP_C, 32'h1000, 1'b1, 1'b1, "R5", 1'b1, 32'h1000, 1 << 5);
        step(4, IP_C, 32'h1000, 1'b1, 1'b1, "R5");

        // R7: lookup in the commit cycle of a failing load sees the old 15
        set_disp(0, IP_A, 32'h100, 1'b1, 1'b1, "R7");
        @(negedge clk); clear_all();
        st_valid = 1'b1; st_dw_addr = 29'(32'h100 >> 3); st_younger_mask = 16'(1);
        @(negedge clk); clear_all();
        cm_valid = 1'b1; cm_slot = 4'd0;
        set_disp(1, IP_A, 32'h100, 1'b1, 1'b1, "R7");
        @(negedge clk); clear_all();
        cm_valid = 1'b1; cm_slot = 4'd1;
        @(negedge clk); clear_all();
        step(1, IP_A, 32'h100, 1'b1, 1'b0, "R7");

        // R8/R9: guard windows from a clean reset
        do_reset();
        for (int k = 0; k < 15; k++)
            step(0, IP_A, 32'h100, 1'b1, 1'b0, "R8");
        for (int k = 0; k < 8; k++)
            step(5, IP_E, 32'h2000, 1'b0, 1'b1, "R9", 1'b1, 32'h2000, 1 << 5);
        for (int k = 0; k < 233; k++)
            step(0, IP_A, 32'h100, 1'b1, 1'b1, "R9");
        for (int k = 0; k < 9; k++)
            step(5, IP_E, 32'h2000, 1'b0, 1'b1, "R8", 1'b1, 32'h2000, 1 << 5);
        for (int k = 0; k < 247; k++)
            step(0, IP_A, 32'h100, 1'b1, 1'b1, "R8");
        for (int k = 0; k < 256; k++)
            step(0, IP_A, 32'h100, 1'b1, 1'b0, "R8");
        step(0, IP_A, 32'h100, 1'b1, 1'b1, "R8");

        repeat (2) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R3: %0d decisions missing, expected 0", sb.size());
        end
        finish_run();
    end
endmodule